// File: doc/BRIEF.md
# Serial Score Buffer with Refill Interrupt

This block sits between a host and a music sequencer. The host reaches it only through a three-wire serial port. Each serial frame carries an 8-bit register index and a 16-bit value. A frame sent to the score index drops its word into a 32-entry first-in-first-out buffer. The sequencer drains that buffer one word at a time through a pop strobe. Frames sent to the control index or the interrupt index update a small set of settings.

The host fills the buffer and then programs a refill point. Next it sets the interrupt enable and then the play bit. Later, the interrupt line tells it when the buffer has drained far enough that another batch of words will fit. The refill point is held as an inverted code: the word count is the buffer depth minus one, minus the code. A clear bit throws away all buffered words at once.

Top module: `score_fifo_port`

## Requirements
- R1: After reset, `empty` is 1, and `full`, `irq`, `overflow` and `play` are 0. The interrupt code is 0 and the enable is off.
- R2: A frame opens while `sync` is low. `sdin` is taken on each rising `sclk`, MSB first: 8 index bits, then 16 data bits. The frame takes effect on the rising `sync` only if exactly 24 bits arrived. A frame of any other length changes nothing.
- R3: A frame to index 00h stores its data word in the buffer. Words leave in the order they were written, and `word_out` shows the oldest word while the buffer is not empty.
- R4: A cycle with `pop` high and the buffer not empty removes the oldest word. A `pop` on an empty buffer has no effect.
- R5: `empty` is 1 exactly when the buffer holds 0 words. `full` is 1 exactly when it holds 32 words.
- R6: A score frame that arrives while the buffer is full is dropped and leaves the contents unchanged. It also sets `overflow`, which then stays 1 until a clear or a reset.
- R7: A frame to index 34h loads the interrupt enable from bit 5 and the 5-bit refill code from bits 4:0. The refill count is 31 minus the code.
- R8: `irq` is 1 exactly when the enable is set and the number of buffered words is at or below the refill count.
- R9: A frame to index 32h sets `play` from bit 0, and `play` holds that value until the next such frame.
- R10: A frame to index 32h with bit 1 set empties the buffer, clears `overflow` and clears the interrupt enable. As a result, `irq` is 0 one clock after the frame takes effect.
- R11: A frame to any other index changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | Frame strobe: low while a frame is sent, rising edge commits |
| sclk | input | 1 | Serial bit clock |
| sdin | input | 1 | Serial data, MSB first |
| pop | input | 1 | Sequencer request to remove the oldest word |
| word_out | output | 16 | Oldest buffered word |
| empty | output | 1 | Buffer holds no words |
| full | output | 1 | Buffer holds 32 words |
| irq | output | 1 | Refill interrupt, active high |
| overflow | output | 1 | Sticky flag: a score word was dropped |
| play | output | 1 | Playback start bit |

## Verification
The assertions assume three things about the inputs. `sync`, `sclk` and `sdin` change slowly compared with `clk`, so each level lasts several clocks after the two-stage synchronizers. `sdin` is stable across every rising `sclk`. `sync` is high outside frames. The bench holds every serial level for four clocks and changes `sdin` only while `sclk` is low. It drives `pop` only between frames, one clock at a time. Random traffic mixes score writes, pops and interrupt settings. Directed cases cover a full buffer, an overflowing write, a pop on an empty buffer, frames with the wrong bit count, unused indexes and the clear bit.

// File: rtl/score_fifo_port.sv
module score_fifo_port #(
  parameter int DW = 16,
  parameter int IW = 8,
  parameter int DEPTH = 32,
  parameter logic [IW-1:0] IDX_SCORE = 'h00,
  parameter logic [IW-1:0] IDX_CTRL  = 'h32,
  parameter logic [IW-1:0] IDX_IRQ   = 'h34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync,
  input  logic          sclk,
  input  logic          sdin,
  input  logic          pop,
  output logic [DW-1:0] word_out,
  output logic          empty,
  output logic          full,
  output logic          irq,
  output logic          overflow,
  output logic          play
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = IW + DW;
  localparam int CW = $clog2(FW) + 1;
  localparam logic [CW-1:0] FW_C = CW'(FW);
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [2:0]    sync_q, sclk_q;
  logic [1:0]    sdin_q;
  logic [FW-1:0] shreg;
  logic [CW-1:0] bitcnt;

  wire frame_open = ~sync_q[1];
  wire sclk_rise  = sclk_q[1] & ~sclk_q[2];
  wire sync_rise  = sync_q[1] & ~sync_q[2];
  wire commit     = sync_rise && (bitcnt == FW_C);

  wire [IW-1:0] idx = shreg[FW-1 -: IW];
  wire [DW-1:0] dat = shreg[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      sclk_q <= '0;
      sdin_q <= '0;
      shreg  <= '0;
      bitcnt <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sync};
      sclk_q <= {sclk_q[1:0], sclk};
      sdin_q <= {sdin_q[0], sdin};
      if (!frame_open) begin
        bitcnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[FW-2:0], sdin_q[1]};
        if (bitcnt != '1) bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  wire wr_score = commit && (idx == IDX_SCORE);
  wire wr_ctrl  = commit && (idx == IDX_CTRL);
  wire wr_irq   = commit && (idx == IDX_IRQ);
  wire clr_go   = wr_ctrl && dat[1];

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          irq_en;
  logic [AW-1:0] irq_code;

  assign empty    = (cnt == '0);
  assign full     = (cnt == DEPTH_C);
  assign word_out = mem[rp];

  wire push_ok = wr_score && !full;
  wire pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= dat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else if (clr_go) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
      else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
      if (wr_score && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      play     <= 1'b0;
      irq_en   <= 1'b0;
      irq_code <= '0;
    end else begin
      if (wr_ctrl) begin
        play <= dat[0];
        if (dat[1]) irq_en <= 1'b0;
      end
      if (wr_irq) begin
        irq_en   <= dat[AW];
        irq_code <= dat[AW-1:0];
      end
    end
  end

  wire [AW:0] refill_cnt = (DEPTH_C - 1'b1) - {1'b0, irq_code};
  assign irq = irq_en && (cnt <= refill_cnt);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEPTH_C);

  // R4
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !wr_score && !clr_go) |=> empty);

  // R6
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_score && full && !pop && !clr_go) |=> (full && overflow && $stable(wp)));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_go) |=> overflow);

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_go |=> (empty && !irq && !overflow));

  // R3
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !clr_go) |=> (rp == $past(rp) + 1'b1));
endmodule

// File: tb/test_score_fifo_port.sv
module test_score_fifo_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b1, sclk = 1'b0, sdin = 1'b0, pop = 1'b0;
  logic [15:0] word_out;
  logic empty, full, irq, overflow, play;

  int checks = 0, errors = 0;
  logic [15:0] mq[$];
  bit m_ovf = 0, m_en = 0, m_play = 0;
  int m_code = 0;

  always #10 clk = ~clk;

  score_fifo_port i_score_fifo_port (
    .clk(clk), .rst_n(rst_n), .sync(sync), .sclk(sclk), .sdin(sdin),
    .pop(pop), .word_out(word_out), .empty(empty), .full(full),
    .irq(irq), .overflow(overflow), .play(play));

  function automatic bit exp_irq();
    return m_en && (mq.size() <= 31 - m_code);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "empty", 32'(empty), 32'(mq.size() == 0));
    chk(tag, "full", 32'(full), 32'(mq.size() == 32));
    chk(tag, "irq", 32'(irq), 32'(exp_irq()));
    chk(tag, "overflow", 32'(overflow), 32'(m_ovf));
    chk(tag, "play", 32'(play), 32'(m_play));
    if (mq.size() > 0) chk(tag, "word_out", 32'(word_out), 32'(mq[0]));
  endtask

  task automatic send(input logic [7:0] idx, input logic [15:0] d, input int nbits);
    logic [23:0] fr = {idx, d};
    @(negedge clk) sync = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdin = (i < 24) ? fr[23-i] : 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    sync = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic push_word(input logic [15:0] d);
    send(8'h00, d, 24);
    if (mq.size() == 32) m_ovf = 1;
    else mq.push_back(d);
  endtask

  task automatic set_irq(input bit en, input int code);
    send(8'h34, 16'(({en, 5'(code)})), 24);
    m_en = en;
    m_code = code;
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
    if (mq.size() > 0) void'(mq.pop_front());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    for (int i = 0; i < 32; i++) push_word(16'(i * 37 + 5));
    check_all("R3 R5 filled");
    push_word(16'hDEAD);
    check_all("R6 overflow drop");

    set_irq(1, 5'h15);
    check_all("R7 code 15h");
    for (int i = 0; i < 24; i++) begin
      do_pop();
      check_all("R8 R3 drain");
    end

    send(8'h00, 16'h1111, 23);
    check_all("R2 short frame");
    send(8'h00, 16'h2222, 25);
    check_all("R2 long frame");
    send(8'h40, 16'hFFFF, 24);
    check_all("R11 unused index");

    send(8'h32, 16'h0001, 24);
    m_play = 1;
    check_all("R9 play set");

    set_irq(1, 5'h1F);
    check_all("R7 code 1Fh");
    send(8'h32, 16'h0003, 24);
    mq.delete();
    m_ovf = 0;
    m_en = 0;
    check_all("R10 clear");

    do_pop();
    check_all("R4 pop empty");
    push_word(16'hBEEF);
    check_all("R3 after clear");

    for (int n = 0; n < 140; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 5) begin
        push_word(16'($urandom));
        check_all("R3 R6 random push");
      end else if (op < 9) begin
        do_pop();
        check_all("R4 R8 random pop");
      end else begin
        set_irq(bit'($urandom_range(0, 1)), $urandom_range(0, 31));
        check_all("R7 R8 random irq");
      end
    end

    send(8'h32, 16'h0000, 24);
    m_play = 0;
    check_all("R9 play clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule